// File: doc/BRIEF.md
# Serial Port Host FIFO Front End

This block sits between a register bus and the shift engine of a serial port. A single data register stands in front of two word-wide queues. In normal operation, host writes fill the outbound queue, which the shift engine drains. The shift engine fills the inbound queue, and host reads drain it. Each queue keeps a registered fill level. The level is compared with a programmable threshold to give a service flag: the outbound flag means "room to refill" and the inbound flag means "data waiting".

Each service flag fans out to an interrupt request and a DMA request. Each request has its own enable, and the enables never alter the flags or the levels. A receive time-out indication from the shift engine is masked the same way into a third interrupt.

A loopback test mode turns the data register into a direct port onto one queue, chosen by a select input. Host writes push into that queue and host reads pop from it, so software can exercise the storage. While this mode is on, the serial side is cut off.

Top module: `sport_fifo_front`

## Requirements
- R1: After reset both levels read 0, `rx_ovr`, `busy` and `ser_tx_avail` are 0, and every request output is 0 while its enable is 0.
- R2: In normal mode (`cfg_test_en`=0), a `bus_wr` pushes `bus_wdata` into the outbound queue. `ser_tx_data` presents the oldest word, and a `ser_tx_pop` removes it, in first-in-first-out order. `busy` is 1 when the outbound queue holds data or `sh_active` is 1.
- R3: In normal mode, a `ser_rx_push` stores `ser_rx_data` in the inbound queue. `bus_rdata` presents the oldest word, and a `bus_rd` removes it, in first-in-first-out order.
- R4: `tx_svc` is 1 exactly when `tx_level` <= `cfg_tx_thresh`. `rx_svc` is 1 exactly when `rx_level` >= `cfg_rx_thresh`.
- R5: `tx_irq` = `tx_svc` AND `cfg_tx_irq_en`, and `tx_dma` = `tx_svc` AND `cfg_tx_dma_en`. The two are independent. With the default REG_REQ=0 they follow in the same cycle.
- R6: `rx_irq` = `rx_svc` AND `cfg_rx_irq_en`, and `rx_dma` = `rx_svc` AND `cfg_rx_dma_en`. The two are independent.
- R7: Changing any enable leaves the service flags and the levels unchanged.
- R8: `tmo_irq` = `rx_tmo` AND `cfg_tmo_irq_en`.
- R9: In normal mode, a serial push into a full inbound queue drops the word, leaves the level at DEPTH and sets `rx_ovr`. `rx_ovr` stays set until an `ovr_clr` pulse.
- R10: With `cfg_test_en`=1 and `cfg_test_sel`=0, `bus_wr` pushes into the outbound queue. `bus_rdata` shows its oldest word, and `bus_rd` pops it in first-in-first-out order.
- R11: With `cfg_test_en`=1 and `cfg_test_sel`=1, `bus_wr` pushes into the inbound queue, and `bus_rd` pops from it in first-in-first-out order.
- R12: In test mode, `ser_tx_avail`, `ser_tx_data`, `busy` and `rx_ovr` are 0, and `ser_rx_push` and `ser_tx_pop` have no effect on either level.
- R13: A push into a full queue and a pop from an empty queue are ignored. A level never exceeds DEPTH (16) or drops below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Data register write strobe |
| bus_rd | input | 1 | Data register read strobe (pops) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Head word of the queue being read (0 if empty) |
| cfg_tx_irq_en | input | 1 | Outbound interrupt enable |
| cfg_tx_dma_en | input | 1 | Outbound DMA enable |
| cfg_rx_irq_en | input | 1 | Inbound interrupt enable |
| cfg_rx_dma_en | input | 1 | Inbound DMA enable |
| cfg_tmo_irq_en | input | 1 | Time-out interrupt enable |
| cfg_test_en | input | 1 | Loopback test mode |
| cfg_test_sel | input | 1 | Test target: 0 outbound, 1 inbound |
| cfg_tx_thresh | input | 5 | Outbound threshold |
| cfg_rx_thresh | input | 5 | Inbound threshold |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_tmo | input | 1 | Receive time-out indication |
| sh_active | input | 1 | Shift engine mid-frame |
| ser_tx_pop | input | 1 | Shift engine takes a word |
| ser_tx_data | output | 32 | Word offered to the shift engine |
| ser_tx_avail | output | 1 | Word available to the shift engine |
| ser_rx_push | input | 1 | Shift engine delivers a word |
| ser_rx_data | input | 32 | Delivered word |
| tx_level | output | 5 | Outbound fill level |
| rx_level | output | 5 | Inbound fill level |
| tx_svc | output | 1 | Outbound service flag |
| rx_svc | output | 1 | Inbound service flag |
| tx_irq | output | 1 | Outbound interrupt request |
| tx_dma | output | 1 | Outbound DMA request |
| rx_irq | output | 1 | Inbound interrupt request |
| rx_dma | output | 1 | Inbound DMA request |
| tmo_irq | output | 1 | Time-out interrupt request |
| rx_ovr | output | 1 | Sticky overrun flag |
| busy | output | 1 | Port busy |

## Verification
The bench fills the inbound queue to its last entry and then pushes once more. A design that wrapped its pointer would overwrite the oldest word, and the 16 words read back would come out of order. A design that skipped the overrun would leave `rx_ovr` low.

The bench toggles each enable on its own while the flag is held. A design that shared one enable between a flag's two requests, or that masked the flag itself, would show the wrong request or a moving `tx_svc`.

In both loopback selections the bench drives serial pushes and pops. A design that left the serial side connected would move a level or raise `ser_tx_avail`. A design that routed the bus to the wrong queue would read back from the other level.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

   // Where the data register is routed this cycle
   typedef enum logic [1:0] {
      ROUTE_NORMAL  = 2'd0,
      ROUTE_LOOP_TX = 2'd1,
      ROUTE_LOOP_RX = 2'd2
   } route_e;

   // Index of each masked request lane
   localparam int unsigned REQ_TX_IRQ = 0;
   localparam int unsigned REQ_TX_DMA = 1;
   localparam int unsigned REQ_RX_IRQ = 2;
   localparam int unsigned REQ_RX_DMA = 3;
   localparam int unsigned REQ_TMO    = 4;
   localparam int unsigned N_REQ      = 5;

endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    level,
   output logic             full,
   output logic             empty
);

   if (WIDTH < 1) begin : g_bad_width
      $error("sfq_fifo: WIDTH must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfq_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign head  = empty ? '0 : mem[rd_ptr];
   assign level = cnt;

   // R13: level stays within the storage
   a_r13_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));
   // R13 / R9: a push into a full queue without a pop keeps it full
   a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop && full |=> full);
   // R13: a pop from an empty queue without a push keeps it empty
   a_r13_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      pop && !push && empty |=> empty);

endmodule

// File: rtl/sfq_req_gate.sv
module sfq_req_gate #(
   parameter int unsigned N       = 5,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flag,
   input  logic [N-1:0] en,
   output logic [N-1:0] req
);

   if (N < 1) begin : g_bad_n
      $error("sfq_req_gate: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_lane
      if (REG_OUT) begin : g_reg
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= flag[i] & en[i];
         end
         assign req[i] = q;

         // R5 R6 R8: a request only follows a set flag
         a_r5_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            req[i] |-> $past(flag[i]));
         // R7: a cleared enable blocks only its own request
         a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!en[i]) |-> !req[i]);
      end else begin : g_comb
         assign req[i] = flag[i] & en[i];

         // R5 R6 R8: a request only follows a set flag
         a_r5_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            req[i] |-> flag[i]);
         // R7: a cleared enable blocks only its own request
         a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> !req[i]);
      end
   end

endmodule

// File: rtl/sport_fifo_front.sv
module sport_fifo_front
   import sfq_pkg::*;
#(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned DEPTH   = 16,
   parameter bit          REG_REQ = 1'b0,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic             cfg_tx_irq_en,
   input  logic             cfg_tx_dma_en,
   input  logic             cfg_rx_irq_en,
   input  logic             cfg_rx_dma_en,
   input  logic             cfg_tmo_irq_en,
   input  logic             cfg_test_en,
   input  logic             cfg_test_sel,
   input  logic [CW-1:0]    cfg_tx_thresh,
   input  logic [CW-1:0]    cfg_rx_thresh,
   input  logic             ovr_clr,
   input  logic             rx_tmo,
   input  logic             sh_active,
   input  logic             ser_tx_pop,
   output logic [WIDTH-1:0] ser_tx_data,
   output logic             ser_tx_avail,
   input  logic             ser_rx_push,
   input  logic [WIDTH-1:0] ser_rx_data,
   output logic [CW-1:0]    tx_level,
   output logic [CW-1:0]    rx_level,
   output logic             tx_svc,
   output logic             rx_svc,
   output logic             tx_irq,
   output logic             tx_dma,
   output logic             rx_irq,
   output logic             rx_dma,
   output logic             tmo_irq,
   output logic             rx_ovr,
   output logic             busy
);

   route_e route;
   always_comb begin
      if (!cfg_test_en)     route = ROUTE_NORMAL;
      else if (cfg_test_sel) route = ROUTE_LOOP_RX;
      else                  route = ROUTE_LOOP_TX;
   end

   logic             tx_push, tx_pop, rx_push, rx_pop, rx_push_ser;
   logic [WIDTH-1:0] rx_din, tx_head, rx_head;
   logic             tx_full, tx_empty, rx_full, rx_empty;

   always_comb begin
      tx_push     = 1'b0;
      tx_pop      = 1'b0;
      rx_push     = 1'b0;
      rx_pop      = 1'b0;
      rx_push_ser = 1'b0;
      rx_din      = ser_rx_data;
      bus_rdata   = rx_head;
      unique case (route)
         ROUTE_LOOP_TX: begin
            tx_push   = bus_wr;
            tx_pop    = bus_rd;
            bus_rdata = tx_head;
         end
         ROUTE_LOOP_RX: begin
            rx_push = bus_wr;
            rx_pop  = bus_rd;
            rx_din  = bus_wdata;
         end
         default: begin
            tx_push     = bus_wr;
            tx_pop      = ser_tx_pop;
            rx_push_ser = ser_rx_push;
            rx_push     = ser_rx_push;
            rx_pop      = bus_rd;
         end
      endcase
   end

   sfq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .din   (bus_wdata),
      .pop   (tx_pop),
      .head  (tx_head),
      .level (tx_level),
      .full  (tx_full),
      .empty (tx_empty)
   );

   sfq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .din   (rx_din),
      .pop   (rx_pop),
      .head  (rx_head),
      .level (rx_level),
      .full  (rx_full),
      .empty (rx_empty)
   );

   // Service flags from registered levels
   assign tx_svc = (tx_level <= cfg_tx_thresh);
   assign rx_svc = (rx_level >= cfg_rx_thresh);

   // Sticky overrun; a new overrun wins over a clear in the same cycle
   logic ovr_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                     ovr_q <= 1'b0;
      else if (rx_push_ser && rx_full) ovr_q <= 1'b1;
      else if (ovr_clr)                ovr_q <= 1'b0;
   end

   logic in_test;
   assign in_test      = (route != ROUTE_NORMAL);
   assign rx_ovr       = ovr_q && !in_test;
   assign ser_tx_avail = !in_test && !tx_empty;
   assign ser_tx_data  = in_test ? '0 : tx_head;
   assign busy         = !in_test && (!tx_empty || sh_active);

   // Masked requests
   logic [N_REQ-1:0] flags, enables, reqs;
   always_comb begin
      flags               = '0;
      enables             = '0;
      flags[REQ_TX_IRQ]   = tx_svc;
      flags[REQ_TX_DMA]   = tx_svc;
      flags[REQ_RX_IRQ]   = rx_svc;
      flags[REQ_RX_DMA]   = rx_svc;
      flags[REQ_TMO]      = rx_tmo;
      enables[REQ_TX_IRQ] = cfg_tx_irq_en;
      enables[REQ_TX_DMA] = cfg_tx_dma_en;
      enables[REQ_RX_IRQ] = cfg_rx_irq_en;
      enables[REQ_RX_DMA] = cfg_rx_dma_en;
      enables[REQ_TMO]    = cfg_tmo_irq_en;
   end

   sfq_req_gate #(.N(N_REQ), .REG_OUT(REG_REQ)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .flag  (flags),
      .en    (enables),
      .req   (reqs)
   );

   assign tx_irq  = reqs[REQ_TX_IRQ];
   assign tx_dma  = reqs[REQ_TX_DMA];
   assign rx_irq  = reqs[REQ_RX_IRQ];
   assign rx_dma  = reqs[REQ_RX_DMA];
   assign tmo_irq = reqs[REQ_TMO];

   // R9: overrun stays set until cleared
   a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q && !ovr_clr |=> ovr_q);
   // R12: in test mode serial pushes leave the inbound level alone
   a_r12_ser_cut_off: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_test_en && ser_rx_push && !bus_wr && !bus_rd |=> $stable(rx_level));
   // R4: an empty outbound queue always asks for service
   a_r4_empty_tx_svc: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level == '0 |-> tx_svc);

endmodule

// File: tb/sport_fifo_front_test.sv
module sport_fifo_front_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr, bus_rd, ovr_clr, rx_tmo, sh_active, ser_tx_pop, ser_rx_push;
   logic [31:0] bus_wdata, ser_rx_data, bus_rdata, ser_tx_data;
   logic        cfg_tx_irq_en, cfg_tx_dma_en, cfg_rx_irq_en, cfg_rx_dma_en, cfg_tmo_irq_en;
   logic        cfg_test_en, cfg_test_sel;
   logic [4:0]  cfg_tx_thresh, cfg_rx_thresh, tx_level, rx_level;
   logic        ser_tx_avail, tx_svc, rx_svc, tx_irq, tx_dma, rx_irq, rx_dma, tmo_irq, rx_ovr, busy;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   logic [31:0] txq[$];
   logic [31:0] rxq[$];

   always #4 clk = ~clk;

   sport_fifo_front uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cfg_tx_irq_en(cfg_tx_irq_en), .cfg_tx_dma_en(cfg_tx_dma_en),
      .cfg_rx_irq_en(cfg_rx_irq_en), .cfg_rx_dma_en(cfg_rx_dma_en),
      .cfg_tmo_irq_en(cfg_tmo_irq_en), .cfg_test_en(cfg_test_en),
      .cfg_test_sel(cfg_test_sel), .cfg_tx_thresh(cfg_tx_thresh),
      .cfg_rx_thresh(cfg_rx_thresh), .ovr_clr(ovr_clr), .rx_tmo(rx_tmo),
      .sh_active(sh_active), .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
      .ser_tx_avail(ser_tx_avail), .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
      .tx_level(tx_level), .rx_level(rx_level), .tx_svc(tx_svc), .rx_svc(rx_svc),
      .tx_irq(tx_irq), .tx_dma(tx_dma), .rx_irq(rx_irq), .rx_dma(rx_dma),
      .tmo_irq(tmo_irq), .rx_ovr(rx_ovr), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, tag, act, exp);
   endtask

   // Driver: host write; expected word goes to the queue it should land in
   task automatic host_wr(input logic [31:0] w, input bit to_rx);
      bus_wdata = w;
      bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (to_rx) begin
         if (rxq.size() < 16) rxq.push_back(w);
      end else begin
         if (txq.size() < 16) txq.push_back(w);
      end
   endtask

   // Monitor side: compare bus head against scoreboard, then pop
   task automatic host_rd(input bit from_tx, input string tag);
      logic [31:0] exp;
      exp = from_tx ? txq.pop_front() : rxq.pop_front();
      eq(tag, bus_rdata, exp);
      bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ser_push(input logic [31:0] w, input bit expect_store);
      ser_rx_data = w;
      ser_rx_push = 1'b1;
      @(negedge clk);
      ser_rx_push = 1'b0;
      if (expect_store && rxq.size() < 16) rxq.push_back(w);
   endtask

   task automatic ser_pop(input string tag);
      eq(tag, {31'd0, ser_tx_avail}, 32'd1);
      eq(tag, ser_tx_data, txq.pop_front());
      ser_tx_pop = 1'b1;
      @(negedge clk);
      ser_tx_pop = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      {bus_wr, bus_rd, ovr_clr, rx_tmo, sh_active, ser_tx_pop, ser_rx_push} = '0;
      bus_wdata = '0; ser_rx_data = '0;
      {cfg_tx_irq_en, cfg_tx_dma_en, cfg_rx_irq_en, cfg_rx_dma_en, cfg_tmo_irq_en} = '0;
      cfg_test_en = 1'b0; cfg_test_sel = 1'b0;
      cfg_tx_thresh = 5'd2; cfg_rx_thresh = 5'd3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      eq("R1 tx_level", tx_level, 0);
      eq("R1 rx_level", rx_level, 0);
      eq("R1 rx_ovr", rx_ovr, 0);
      eq("R1 busy", busy, 0);
      eq("R1 ser_tx_avail", ser_tx_avail, 0);
      eq("R1 requests", {tx_irq, tx_dma, rx_irq, rx_dma, tmo_irq}, 0);
      eq("R4 tx_svc empty", tx_svc, 1);
      eq("R4 rx_svc empty", rx_svc, 0);

      // R2 outbound path, R4 threshold
      host_wr(32'hA000_0001, 0);
      host_wr(32'hA000_0002, 0);
      eq("R4 tx_svc at thresh", tx_svc, 1);
      host_wr(32'hA000_0003, 0);
      eq("R2 tx_level", tx_level, 3);
      eq("R2 busy with data", busy, 1);
      eq("R4 tx_svc above thresh", tx_svc, 0);
      cfg_tx_irq_en = 1'b1;
      #1;
      eq("R5 irq blocked by flag", tx_irq, 0);
      @(negedge clk);
      ser_pop("R2 order 1");
      eq("R5 tx_irq", tx_irq, 1);
      eq("R5 tx_dma masked", tx_dma, 0);
      cfg_tx_irq_en = 1'b0; cfg_tx_dma_en = 1'b1;
      #1;
      eq("R5 tx_dma alone", tx_dma, 1);
      eq("R5 tx_irq masked", tx_irq, 0);
      eq("R7 tx_svc kept", tx_svc, 1);
      eq("R7 tx_level kept", tx_level, 2);
      cfg_tx_dma_en = 1'b0;
      #1;
      eq("R7 tx_svc after mask", tx_svc, 1);
      @(negedge clk);
      ser_pop("R2 order 2");
      ser_pop("R2 order 3");
      eq("R2 busy idle", busy, 0);
      sh_active = 1'b1;
      #1;
      eq("R2 busy shifter", busy, 1);
      sh_active = 1'b0;
      @(negedge clk);

      // R3 inbound path, R6
      ser_push(32'hB000_0001, 1);
      ser_push(32'hB000_0002, 1);
      eq("R4 rx_svc below", rx_svc, 0);
      ser_push(32'hB000_0003, 1);
      eq("R4 rx_svc at thresh", rx_svc, 1);
      cfg_rx_irq_en = 1'b1;
      #1;
      eq("R6 rx_irq", rx_irq, 1);
      eq("R6 rx_dma masked", rx_dma, 0);
      cfg_rx_irq_en = 1'b0; cfg_rx_dma_en = 1'b1;
      #1;
      eq("R6 rx_dma alone", rx_dma, 1);
      eq("R6 rx_irq masked", rx_irq, 0);
      eq("R7 rx_level kept", rx_level, 3);
      cfg_rx_dma_en = 1'b0;
      @(negedge clk);
      host_rd(0, "R3 order 1");
      host_rd(0, "R3 order 2");
      host_rd(0, "R3 order 3");
      eq("R3 rx drained", rx_level, 0);

      // R8 time-out mask
      rx_tmo = 1'b1;
      #1;
      eq("R8 tmo masked", tmo_irq, 0);
      cfg_tmo_irq_en = 1'b1;
      #1;
      eq("R8 tmo enabled", tmo_irq, 1);
      rx_tmo = 1'b0;
      #1;
      eq("R8 tmo dropped", tmo_irq, 0);
      cfg_tmo_irq_en = 1'b0;
      @(negedge clk);

      // R13 pop from empty
      bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      eq("R13 empty pop", rx_level, 0);

      // R9 overrun
      for (int i = 0; i < 16; i++) ser_push(32'hC000_0000 + i, 1);
      eq("R9 full level", rx_level, 16);
      eq("R9 no ovr yet", rx_ovr, 0);
      ser_push(32'hDEAD_BEEF, 0);
      eq("R9 ovr set", rx_ovr, 1);
      eq("R9 level capped", rx_level, 16);
      for (int i = 0; i < 16; i++) host_rd(0, "R9 order after overrun");
      eq("R9 ovr sticky", rx_ovr, 1);
      ovr_clr = 1'b1;
      @(negedge clk);
      ovr_clr = 1'b0;
      eq("R9 ovr cleared", rx_ovr, 0);

      // R13 push into full outbound
      for (int i = 0; i < 17; i++) host_wr(32'hE000_0000 + i, 0);
      eq("R13 tx capped", tx_level, 16);
      for (int i = 0; i < 16; i++) ser_pop("R13 order after full");
      eq("R13 tx drained", tx_level, 0);

      // R10 loopback outbound
      cfg_test_en = 1'b1; cfg_test_sel = 1'b0;
      for (int i = 0; i < 4; i++) host_wr(32'h7100_0000 + i, 0);
      eq("R10 tx level", tx_level, 4);
      eq("R10 rx untouched", rx_level, 0);
      eq("R12 no tx avail", ser_tx_avail, 0);
      eq("R12 no tx data", ser_tx_data, 0);
      sh_active = 1'b1;
      #1;
      eq("R12 busy held", busy, 0);
      sh_active = 1'b0;
      @(negedge clk);
      ser_push(32'h5555_5555, 0);
      eq("R12 ser push ignored", rx_level, 0);
      ser_tx_pop = 1'b1;
      @(negedge clk);
      ser_tx_pop = 1'b0;
      eq("R12 ser pop ignored", tx_level, 4);
      for (int i = 0; i < 4; i++) host_rd(1, "R10 loop order");
      eq("R10 tx drained", tx_level, 0);

      // R11 loopback inbound, R12 overrun held inactive
      cfg_test_sel = 1'b1;
      for (int i = 0; i < 16; i++) host_wr(32'h7200_0000 + i, 1);
      eq("R11 rx level", rx_level, 16);
      eq("R11 tx untouched", tx_level, 0);
      ser_push(32'h6666_6666, 0);
      eq("R12 no ovr in test", rx_ovr, 0);
      eq("R12 full level kept", rx_level, 16);
      for (int i = 0; i < 16; i++) host_rd(0, "R11 loop order");
      eq("R11 rx drained", rx_level, 0);
      cfg_test_en = 1'b0;
      @(negedge clk);
      eq("R12 ovr after test", rx_ovr, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule